// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block shifts or rotates a 32-bit operand by an amount taken from the low byte of a register. It also produces the carry that the shift would leave behind. It sits in the second-operand path of an integer datapath, between operand read and the ALU, and is purely combinational.

The amount is a full 8-bit value. The result and carry therefore follow separate rules at zero, at exactly the data width, and beyond it. Only rotation reduces the amount modulo the width.

A 2-bit kind code selects the operation:

| Code | Operation |
|------|-----------|
| 2'b00 | logical left |
| 2'b01 | logical right |
| 2'b10 | arithmetic right |
| 2'b11 | rotate right |

The incoming carry flag is passed through whenever the amount is zero.

Top module: `regshift_carry_unit`

## Requirements
- R1: With `shamt_i` equal to 0, for any kind code, `result_o` equals `operand_i` and `carry_o` equals `carry_i`.
- R2: Kind 2'b00 (logical left) with amount 1 to 31 gives `operand_i << amount`, and the carry is operand bit (32 − amount).
- R3: Kind 2'b00 with amount exactly 32 gives result 0 and carry equal to operand bit 0. With amount 33 to 255 it gives result 0 and carry 0.
- R4: Kind 2'b01 (logical right) with amount 1 to 31 gives `operand_i >> amount` (zero fill), and the carry is operand bit (amount − 1).
- R5: Kind 2'b01 with amount exactly 32 gives result 0 and carry equal to operand bit 31. With amount 33 to 255 it gives result 0 and carry 0.
- R6: Kind 2'b10 (arithmetic right) with amount 1 to 31 fills vacated bits with operand bit 31, and the carry is operand bit (amount − 1).
- R7: Kind 2'b10 with amount 32 to 255 gives all ones with carry 1 when operand bit 31 is 1. Otherwise it gives result 0 with carry 0.
- R8: Kind 2'b11 (rotate right) with a nonzero amount whose low five bits are zero (32, 64, 96, …) returns the operand unchanged, with carry equal to operand bit 31.
- R9: Kind 2'b11 with nonzero low five bits rotates right by (amount mod 32), and the carry equals result bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| shamt_i | input | 8 | Shift amount (low byte of the amount register) |
| kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Two rules can both leave the operand unchanged for a single input set, yet demand different carries:
- the zero-amount pass-through, which forwards `carry_i`;
- the rotate by a multiple of 32, which yields operand bit 31.

The bench provokes this by applying rotate with amounts 0, 32, 64 and 96, using operands whose bit 31 differs from `carry_i`. A correct design is judged by the carry tracking `carry_i` only at amount 0, while the result stays equal to the operand in all four cases. Likewise, amount 32 against 33 and 255 separates the exact-width rule from the over-width rule for every kind.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned AMT_W  = 8;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } shift_out_t;

    // number of amount bits needed to express 0..width inclusive
    function automatic int unsigned span_bits(int unsigned width);
        return $clog2(width) + 1;
    endfunction

endpackage

// File: rtl/regshift_lsl_unit.sv
module regshift_lsl_unit #(
    parameter int unsigned WIDTH = regshift_pkg::DATA_W,
    parameter int unsigned AMT_W = regshift_pkg::AMT_W
) (
    input  logic [WIDTH-1:0] op,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] value,
    output logic             carry
);
    localparam int unsigned       STG = regshift_pkg::span_bits(WIDTH);
    localparam logic [AMT_W-1:0] LIM = AMT_W'(WIDTH);

    // carry slot at bit WIDTH collects the last bit pushed out
    logic [WIDTH:0] stg [STG+1];
    logic           over;

    assign stg[0] = {1'b0, op};
    assign over   = (amt > LIM);

    for (genvar k = 0; k < STG; k++) begin : g_stage
        assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
    end

    assign value = over ? '0   : stg[STG][WIDTH-1:0];
    assign carry = over ? 1'b0 : stg[STG][WIDTH];

    always_comb begin
        if (!$isunknown({op, amt}) && amt != '0 && amt < LIM) begin
            assert_lsl_carry_R2: assert (carry == op[WIDTH - int'(amt)])
                else $error("lsl carry mismatch");
        end
    end
endmodule

// File: rtl/regshift_shr_unit.sv
module regshift_shr_unit #(
    parameter int unsigned WIDTH = regshift_pkg::DATA_W,
    parameter int unsigned AMT_W = regshift_pkg::AMT_W,
    parameter bit          ARITH = 1'b0
) (
    input  logic [WIDTH-1:0] op,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] value,
    output logic             carry
);
    localparam int unsigned       STG = regshift_pkg::span_bits(WIDTH);
    localparam logic [AMT_W-1:0] LIM = AMT_W'(WIDTH);

    // guard slot at bit 0 collects the last bit pushed out
    logic [WIDTH:0]   stg [STG+1];
    logic             over;
    logic             fill;
    logic [AMT_W-1:0] eff;

    assign over   = (amt > LIM);
    assign stg[0] = {op, 1'b0};

    if (ARITH) begin : g_arith
        // shifting by the full width already saturates to sign copies
        assign fill  = op[WIDTH-1];
        assign eff   = over ? LIM : amt;
        assign value = stg[STG][WIDTH:1];
        assign carry = stg[STG][0];
    end else begin : g_logic
        assign fill  = 1'b0;
        assign eff   = amt;
        assign value = over ? '0   : stg[STG][WIDTH:1];
        assign carry = over ? 1'b0 : stg[STG][0];
    end

    for (genvar k = 0; k < STG; k++) begin : g_stage
        assign stg[k+1] = eff[k] ? {{(1 << k){fill}}, stg[k][WIDTH:(1 << k)]}
                                 : stg[k];
    end

    always_comb begin
        if (!$isunknown({op, amt}) && amt != '0 && amt < LIM) begin
            // also covers R6 when ARITH is set
            assert_shr_carry_R4: assert (carry == op[int'(amt) - 1])
                else $error("right-shift carry mismatch");
        end
        if (ARITH && !$isunknown({op, amt}) && amt >= LIM) begin
            assert_asr_saturate_R7: assert (value == {WIDTH{op[WIDTH-1]}} && carry == op[WIDTH-1])
                else $error("asr saturation mismatch");
        end
    end
endmodule

// File: rtl/regshift_ror_unit.sv
module regshift_ror_unit #(
    parameter int unsigned WIDTH = regshift_pkg::DATA_W,
    localparam int unsigned LOG_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op,
    input  logic [LOG_W-1:0] rot,
    output logic [WIDTH-1:0] value,
    output logic             carry
);
    logic [WIDTH-1:0] stg [LOG_W+1];

    assign stg[0] = op;

    for (genvar k = 0; k < LOG_W; k++) begin : g_stage
        assign stg[k+1] = rot[k] ? {stg[k][(1 << k)-1:0], stg[k][WIDTH-1:(1 << k)]}
                                 : stg[k];
    end

    assign value = stg[LOG_W];
    // a zero residue leaves the operand in place, so its top bit is the carry too
    assign carry = value[WIDTH-1];

    always_comb begin
        if (!$isunknown({op, rot})) begin
            assert_ror_popcount_R9: assert ($countones(value) == $countones(op))
                else $error("rotation changed bit population");
        end
    end
endmodule

// File: rtl/regshift_carry_unit.sv
module regshift_carry_unit
    import regshift_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W,
    parameter int unsigned AMTW  = AMT_W
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMTW-1:0]  shamt_i,
    input  logic [1:0]       kind_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int unsigned       LOG_W = $clog2(WIDTH);
    localparam logic [AMTW-1:0]  LIM   = AMTW'(WIDTH);

    shift_kind_e kind;
    shift_out_t  lsl_o, lsr_o, asr_o, ror_o, sel;

    assign kind = shift_kind_e'(kind_i);

    regshift_lsl_unit #(.WIDTH(WIDTH), .AMT_W(AMTW)) u_lsl (
        .op(operand_i), .amt(shamt_i), .value(lsl_o.value), .carry(lsl_o.carry));

    regshift_shr_unit #(.WIDTH(WIDTH), .AMT_W(AMTW), .ARITH(1'b0)) u_lsr (
        .op(operand_i), .amt(shamt_i), .value(lsr_o.value), .carry(lsr_o.carry));

    regshift_shr_unit #(.WIDTH(WIDTH), .AMT_W(AMTW), .ARITH(1'b1)) u_asr (
        .op(operand_i), .amt(shamt_i), .value(asr_o.value), .carry(asr_o.carry));

    regshift_ror_unit #(.WIDTH(WIDTH)) u_ror (
        .op(operand_i), .rot(shamt_i[LOG_W-1:0]), .value(ror_o.value), .carry(ror_o.carry));

    always_comb begin
        if (shamt_i == '0) begin
            sel.value = operand_i;
            sel.carry = carry_i;
        end else begin
            unique case (kind)
                SHK_LSL: sel = lsl_o;
                SHK_LSR: sel = lsr_o;
                SHK_ASR: sel = asr_o;
                default: sel = ror_o;
            endcase
        end
    end

    assign result_o = sel.value;
    assign carry_o  = sel.carry;

    always_comb begin
        if (!$isunknown({kind_i, shamt_i}) && shamt_i > LIM &&
            (kind == SHK_LSL || kind == SHK_LSR)) begin
            // logical shifts beyond the width clear everything (R3, R5)
            assert_wide_clear_R3: assert (result_o == '0 && carry_o == 1'b0)
                else $error("over-width logical shift not cleared");
        end
    end
endmodule

// File: tb/regshift_carry_unit_tb.sv
module regshift_carry_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand_i = '0;
    logic [7:0]  shamt_i = '0;
    logic [1:0]  kind_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    regshift_carry_unit dut_i (
        .operand_i(operand_i), .shamt_i(shamt_i), .kind_i(kind_i),
        .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o));

    typedef struct packed {
        logic [31:0] op;
        logic [7:0]  amt;
        logic [1:0]  kind;
        logic        cin;
        logic [31:0] val;
        logic        cout;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h8000_0001, 8'd1,   2'b00, 1'b0, 32'h0000_0002, 1'b1, 4'd2}, // R2
        '{32'h8000_0001, 8'd32,  2'b00, 1'b0, 32'h0000_0000, 1'b1, 4'd3}, // R3
        '{32'h8000_0001, 8'd33,  2'b00, 1'b1, 32'h0000_0000, 1'b0, 4'd3}, // R3
        '{32'h8000_0001, 8'd1,   2'b01, 1'b0, 32'h4000_0000, 1'b1, 4'd4}, // R4
        '{32'h8000_0001, 8'd32,  2'b01, 1'b0, 32'h0000_0000, 1'b1, 4'd5}, // R5
        '{32'h8000_0001, 8'd200, 2'b01, 1'b1, 32'h0000_0000, 1'b0, 4'd5}, // R5
        '{32'h8000_0000, 8'd4,   2'b10, 1'b1, 32'hF800_0000, 1'b0, 4'd6}, // R6
        '{32'h8000_0008, 8'd4,   2'b10, 1'b0, 32'hF800_0000, 1'b1, 4'd6}, // R6
        '{32'h8000_0000, 8'd255, 2'b10, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'd7}, // R7
        '{32'h7FFF_FFFF, 8'd40,  2'b10, 1'b1, 32'h0000_0000, 1'b0, 4'd7}, // R7
        '{32'h1234_5678, 8'd64,  2'b11, 1'b1, 32'h1234_5678, 1'b0, 4'd8}, // R8
        '{32'h8765_4321, 8'd32,  2'b11, 1'b0, 32'h8765_4321, 1'b1, 4'd8}, // R8
        '{32'h0000_0001, 8'd33,  2'b11, 1'b0, 32'h8000_0000, 1'b1, 4'd9}, // R9
        '{32'h1234_5678, 8'd4,   2'b11, 1'b0, 32'h8123_4567, 1'b1, 4'd9}, // R9
        '{32'hDEAD_BEEF, 8'd0,   2'b11, 1'b1, 32'hDEAD_BEEF, 1'b1, 4'd1}, // R1
        '{32'hDEAD_BEEF, 8'd0,   2'b00, 1'b0, 32'hDEAD_BEEF, 1'b0, 4'd1}  // R1
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(input string tag, input logic [31:0] exp_v, input logic exp_c);
        n_chk++;
        if (result_o !== exp_v || carry_o !== exp_c) begin
            n_fail++;
            $display("FAIL %s: op=%h amt=%0d kind=%0d cin=%b got result=%h carry=%b expected result=%h carry=%b",
                     tag, operand_i, shamt_i, kind_i, carry_i, result_o, carry_o, exp_v, exp_c);
        end
    endtask

    task automatic apply(input logic [31:0] op, input logic [7:0] amt,
                         input logic [1:0] kind, input logic cin);
        @(negedge clk);
        operand_i = op;
        shamt_i   = amt;
        kind_i    = kind;
        carry_i   = cin;
        #2;
    endtask

    // reference written from the requirements
    function automatic logic [32:0] model(input logic [31:0] op, input int amt,
                                          input logic [1:0] kind, input logic cin);
        logic [31:0] v;
        logic        c;
        int          r;
        if (amt == 0) return {op, cin};                         // R1
        case (kind)
            2'b00: if (amt < 32) begin v = op << amt; c = op[32 - amt]; end      // R2
                   else if (amt == 32) begin v = '0; c = op[0]; end             // R3
                   else begin v = '0; c = 1'b0; end
            2'b01: if (amt < 32) begin v = op >> amt; c = op[amt - 1]; end       // R4
                   else if (amt == 32) begin v = '0; c = op[31]; end            // R5
                   else begin v = '0; c = 1'b0; end
            2'b10: if (amt < 32) begin v = 32'($signed(op) >>> amt); c = op[amt - 1]; end // R6
                   else begin v = {32{op[31]}}; c = op[31]; end                 // R7
            default: begin
                r = amt % 32;
                if (r == 0) begin v = op; c = op[31]; end                        // R8
                else begin v = (op >> r) | (op << (32 - r)); c = v[31]; end      // R9
            end
        endcase
        return {v, c};
    endfunction

    localparam int NA = 12;
    localparam int AMTS [NA] = '{0, 1, 2, 16, 31, 32, 33, 63, 64, 96, 128, 255};

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [32:0] exp;
        logic [31:0] rnd;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        // reset state: zero inputs pass straight through (R1)
        #2;
        check("R1 reset state", 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].amt, VECS[i].kind, VECS[i].cin);
            check($sformatf("R%0d table[%0d]", VECS[i].req, i), VECS[i].val, VECS[i].cout);
        end

        // sweep all kinds over boundary amounts, random operands, both carries
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < NA; a++) begin
                for (int c = 0; c < 2; c++) begin
                    rnd = $urandom;
                    exp = model(rnd, AMTS[a], 2'(k), 1'(c));
                    apply(rnd, 8'(AMTS[a]), 2'(k), 1'(c));
                    check($sformatf("sweep kind=%0d amt=%0d (R1..R9 model)", k, AMTS[a]),
                          exp[32:1], exp[0]);
                end
            end
        end

        // R1 vs R8 collision: unchanged operand, carry source must differ
        apply(32'h8000_00F0, 8'd0, 2'b11, 1'b0);
        check("R1 rotate amount zero keeps carry_i", 32'h8000_00F0, 1'b0);
        apply(32'h8000_00F0, 8'd96, 2'b11, 1'b0);
        check("R8 rotate amount 96 carry from bit31", 32'h8000_00F0, 1'b1);
        apply(32'h0000_00F0, 8'd64, 2'b11, 1'b1);
        check("R8 rotate amount 64 carry from bit31", 32'h0000_00F0, 1'b0);

        // boundary 31/32/33 on logical left with distinct bits 0 and 1
        apply(32'h0000_0003, 8'd31, 2'b00, 1'b0);
        check("R2 lsl by 31", 32'h8000_0000, 1'b1);
        apply(32'h0000_0001, 8'd32, 2'b00, 1'b0);
        check("R3 lsl by 32", 32'h0, 1'b1);
        apply(32'hFFFF_FFFF, 8'd255, 2'b00, 1'b1);
        check("R3 lsl by 255", 32'h0, 1'b0);
        apply(32'hC000_0000, 8'd31, 2'b01, 1'b0);
        check("R4 lsr by 31", 32'h0000_0001, 1'b1);
        apply(32'h7FFF_FFFF, 8'd32, 2'b01, 1'b1);
        check("R5 lsr by 32 bit31 clear", 32'h0, 1'b0);
        apply(32'h8000_0000, 8'd31, 2'b10, 1'b0);
        check("R6 asr by 31", 32'hFFFF_FFFF, 1'b0);
        apply(32'h8000_0000, 8'd32, 2'b10, 1'b0);
        check("R7 asr by 32", 32'hFFFF_FFFF, 1'b1);

        summary();
        $finish;
    end
endmodule